// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a bus-master Ethernet controller. It moves each incoming frame from a byte stream into buffers in shared memory. The buffers are described by a power-of-two ring of four-word descriptors. For every frame it takes the descriptor at the current ring index, checks that the controller owns it, reads the buffer address and buffer length, and stores the frame bytes. A frame that does not fit continues into the next descriptor. At the end it writes the message length and then a flag byte that returns ownership to the host. It then raises a one-cycle receive interrupt.

The byte stream carries the whole frame, including its four trailing CRC bytes. CRC-error and framing-error indications arrive with the final byte. The memory port is 16 bits wide and word addressed, with byte enables and one cycle of read latency. The port accepts one request every cycle. The ring base is given as a word address. A configuration word gives log2 of the ring size in bits 15:13.

Top module: `rx_desc_writer`

## Requirements
- R1: Descriptor n sits at word address ring_base + 4*n. Word 0 is the low 16 bits of the buffer byte address. Word 1 holds the flag byte in bits 15:8 and the high address byte in bits 7:0. Word 2 holds the buffer length as a two's-complement negative; its low 12 bits, negated, give the length, and 0 means 4096. Word 3 is the message length.
- R2: Frame byte k goes to buffer byte address base + k. An even byte address writes bits 15:8 with byte enable 2'b10. An odd byte address writes bits 7:0 with byte enable 2'b01.
- R3: A frame that fits one buffer is closed with flag 0x03 (bit 0 end of packet, bit 1 start of packet, bit 7 ownership cleared) and the high address byte unchanged. Its message word is the number of bytes received, CRC bytes included, in bits 11:0.
- R4: On every write-back the message word is written before the flag word, so ownership is released last.
- R5: A frame longer than its buffer chains into the following descriptors. The first descriptor gets only start of packet. Middle descriptors get no packet bits. The last one gets end of packet and the frame total. Descriptors before the last have a message word of 0.
- R6: CRC error sets flag bit 3 and framing error sets flag bit 5. Both appear only on the end-of-packet descriptor. Bit 6 is set exactly when any of bits 2 to 5 is set.
- R7: If the descriptor at the current index is host-owned when a frame starts, the block writes nothing to memory. It drains the frame, pulses miss_o for one cycle and leaves the ring index unchanged.
- R8: If a chained frame meets a host-owned descriptor, the full descriptor is closed with buffer error (bit 2), overflow (bit 4) and error summary (bit 6), plus start of packet if it was the first, and without end of packet. Its message word is the number of bytes stored. The rest of the frame is discarded. The index moves to the host-owned descriptor, which is left untouched.
- R9: rx_int_o pulses for one cycle, the cycle after the closing flag write, once per frame that stored data. It does not pulse per descriptor.
- R10: The ring holds 2^cfg[15:13] descriptors, and the index wraps from size-1 to 0.
- R11: During and right after reset, rx_ready_o, mem_req_o, rx_int_o and miss_o are low and the index is 0.
- R12: rx_ready_o is low while descriptors are being fetched or written back. A byte is taken only when rx_valid_i and rx_ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_base_i | input | MEM_AW | Word address of descriptor 0 |
| ring_cfg_i | input | 16 | Ring length word, log2 size in bits 15:13 |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_ready_o | output | 1 | Frame byte accepted this cycle when valid |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Final byte of the frame |
| rx_crc_err_i | input | 1 | CRC error, sampled with the final byte |
| rx_frame_err_i | input | 1 | Framing error, sampled with the final byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | MEM_AW | Word address |
| mem_be_o | output | 2 | Byte enables, bit 1 = bits 15:8 |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after a read request |
| rx_int_o | output | 1 | Receive interrupt pulse |
| miss_o | output | 1 | Missed-frame pulse |

## Verification
The bench chains a frame across three descriptors, starting at an odd buffer address. A wrong negated-length decode or a swapped byte lane would scatter the data or close the wrong descriptor. It checks that error bits land only on the last descriptor and that the interrupt count grows by one per frame. A design that flags every descriptor, or pulses per descriptor, is caught. A frame aimed at a host-owned descriptor must cause zero memory writes and must not move the index: the host re-arms that same slot after the ring wraps, and the next frame is expected there. A truncated chain must leave the host-owned descriptor untouched and must make the next frame miss.

// File: rtl/rx_desc_pkg.sv
package rx_desc_pkg;
  localparam int FLG_ENP  = 0;
  localparam int FLG_STP  = 1;
  localparam int FLG_BUFF = 2;
  localparam int FLG_CRC  = 3;
  localparam int FLG_OFLO = 4;
  localparam int FLG_FRAM = 5;
  localparam int FLG_ERR  = 6;
  localparam int FLG_OWN  = 7;

  localparam int LOG_W = 3;
  localparam int IDX_W = (1 << LOG_W) - 1;

  typedef enum logic [3:0] {
    S_IDLE, S_OWN_CHK, S_GET_LO, S_GET_LEN, S_DATA,
    S_NXT, S_NXT_CHK, S_WB_LEN, S_WB_FLG, S_REFETCH, S_DROP
  } st_e;

  typedef enum logic [1:0] {WB_END, WB_MID, WB_TRUNC} wb_e;

  function automatic logic [11:0] neg_len(input logic [11:0] w);
    return 12'(~w + 12'd1);
  endfunction
endpackage

// File: rtl/rx_ring_idx.sv
module rx_ring_idx
  import rx_desc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LOG_W-1:0] log2_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] nxt_o
);
  logic [IDX_W:0]   size_w;
  logic [IDX_W-1:0] mask_w;
  logic [IDX_W-1:0] idx_q;

  assign size_w = (IDX_W+1)'(1) << log2_i;
  assign mask_w = IDX_W'(size_w - (IDX_W+1)'(1));
  assign nxt_o  = (idx_q + IDX_W'(1)) & mask_w;
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= nxt_o;
  end

  p_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && idx_q == mask_w && $stable(log2_i)) |=> (idx_q == '0));
endmodule

// File: rtl/rx_lane_gen.sv
module rx_lane_gen #(
  parameter int MEM_AW = 23
) (
  input  logic [7:0]        base_hi_i,
  input  logic [15:0]       base_lo_i,
  input  logic [11:0]       off_i,
  input  logic [7:0]        data_i,
  output logic [MEM_AW-1:0] waddr_o,
  output logic [1:0]        be_o,
  output logic [15:0]       wdata_o
);
  logic [23:0] byte_addr;

  assign byte_addr = {base_hi_i, base_lo_i} + 24'(off_i);
  assign waddr_o   = byte_addr[MEM_AW:1];
  // big-endian lanes: even byte in the upper half
  assign be_o      = byte_addr[0] ? 2'b01 : 2'b10;
  assign wdata_o   = {data_i, data_i};
endmodule

// File: rtl/rx_flag_build.sv
module rx_flag_build
  import rx_desc_pkg::*;
(
  input  wb_e        mode_i,
  input  logic       first_i,
  input  logic       crc_i,
  input  logic       fram_i,
  output logic [7:0] flag_o
);
  always_comb begin
    flag_o = '0;
    flag_o[FLG_STP] = first_i;
    case (mode_i)
      WB_END: begin
        flag_o[FLG_ENP]  = 1'b1;
        flag_o[FLG_CRC]  = crc_i;
        flag_o[FLG_FRAM] = fram_i;
      end
      WB_TRUNC: begin
        flag_o[FLG_BUFF] = 1'b1;
        flag_o[FLG_OFLO] = 1'b1;
      end
      default: ;
    endcase
    flag_o[FLG_ERR] = |flag_o[FLG_FRAM:FLG_BUFF];
  end
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
  import rx_desc_pkg::*;
#(
  parameter int MEM_AW = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MEM_AW-1:0] ring_base_i,
  input  logic [15:0]       ring_cfg_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rx_crc_err_i,
  input  logic              rx_frame_err_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [1:0]        mem_be_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              rx_int_o,
  output logic              miss_o
);
  st_e         state_q;
  wb_e         mode_q;
  logic        first_q, crc_q, fram_q, rint_q, miss_q;
  logic [7:0]  hi_q, nhi_q;
  logic [15:0] lo_q;
  logic [11:0] blen_q, cnt_q, tot_q;

  logic [IDX_W-1:0]  idx_w, nxt_w;
  logic [MEM_AW-1:0] lane_addr;
  logic [1:0]        lane_be;
  logic [15:0]       lane_data;
  logic [7:0]        flag_w;
  logic              adv_w, take_w;

  assign adv_w  = (state_q == S_WB_FLG);
  assign take_w = rx_valid_i && rx_ready_o;

  rx_ring_idx u_idx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .log2_i(ring_cfg_i[15:13]),
    .adv_i (adv_w),
    .idx_o (idx_w),
    .nxt_o (nxt_w)
  );

  rx_lane_gen #(.MEM_AW(MEM_AW)) u_lane (
    .base_hi_i(hi_q),
    .base_lo_i(lo_q),
    .off_i    (cnt_q),
    .data_i   (rx_data_i),
    .waddr_o  (lane_addr),
    .be_o     (lane_be),
    .wdata_o  (lane_data)
  );

  rx_flag_build u_flag (
    .mode_i (mode_q),
    .first_i(first_q),
    .crc_i  (crc_q),
    .fram_i (fram_q),
    .flag_o (flag_w)
  );

  function automatic logic [MEM_AW-1:0] desc_a(input logic [IDX_W-1:0] i,
                                               input logic [1:0] w);
    return ring_base_i + MEM_AW'({i, w});
  endfunction

  assign rx_ready_o = (state_q == S_DATA) || (state_q == S_DROP);
  assign rx_int_o   = rint_q;
  assign miss_o     = miss_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = 2'b00;
    mem_wdata_o = '0;
    case (state_q)
      S_IDLE: if (rx_valid_i) begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_a(idx_w, 2'd1);
      end
      S_OWN_CHK, S_REFETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_a(idx_w, 2'd0);
      end
      S_GET_LO: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_a(idx_w, 2'd2);
      end
      S_DATA: if (rx_valid_i) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = lane_addr;
        mem_be_o    = lane_be;
        mem_wdata_o = lane_data;
      end
      S_NXT: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_a(nxt_w, 2'd1);
      end
      S_WB_LEN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = 2'b11;
        mem_addr_o  = desc_a(idx_w, 2'd3);
        mem_wdata_o = (mode_q == WB_MID) ? 16'h0 : {4'h0, tot_q};
      end
      S_WB_FLG: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = 2'b11;
        mem_addr_o  = desc_a(idx_w, 2'd1);
        mem_wdata_o = {flag_w, hi_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= WB_END;
      first_q <= 1'b0;
      crc_q   <= 1'b0;
      fram_q  <= 1'b0;
      rint_q  <= 1'b0;
      miss_q  <= 1'b0;
      hi_q    <= '0;
      nhi_q   <= '0;
      lo_q    <= '0;
      blen_q  <= '0;
      cnt_q   <= '0;
      tot_q   <= '0;
    end else begin
      rint_q <= 1'b0;
      miss_q <= 1'b0;
      case (state_q)
        S_IDLE: if (rx_valid_i) begin
          first_q <= 1'b1;
          tot_q   <= '0;
          crc_q   <= 1'b0;
          fram_q  <= 1'b0;
          state_q <= S_OWN_CHK;
        end
        S_OWN_CHK: begin
          if (mem_rdata_i[8+FLG_OWN]) begin
            hi_q    <= mem_rdata_i[7:0];
            state_q <= S_GET_LO;
          end else begin
            miss_q  <= 1'b1;
            state_q <= S_DROP;
          end
        end
        S_GET_LO: begin
          lo_q    <= mem_rdata_i;
          state_q <= S_GET_LEN;
        end
        S_GET_LEN: begin
          blen_q  <= neg_len(mem_rdata_i[11:0]);
          cnt_q   <= '0;
          state_q <= S_DATA;
        end
        S_DATA: if (rx_valid_i) begin
          cnt_q <= cnt_q + 12'd1;
          tot_q <= tot_q + 12'd1;
          if (rx_last_i) begin
            crc_q   <= rx_crc_err_i;
            fram_q  <= rx_frame_err_i;
            mode_q  <= WB_END;
            state_q <= S_WB_LEN;
          end else if (cnt_q + 12'd1 == blen_q) begin
            state_q <= S_NXT;
          end
        end
        S_NXT: state_q <= S_NXT_CHK;
        S_NXT_CHK: begin
          if (mem_rdata_i[8+FLG_OWN]) begin
            nhi_q  <= mem_rdata_i[7:0];
            mode_q <= WB_MID;
          end else begin
            mode_q <= WB_TRUNC;
          end
          state_q <= S_WB_LEN;
        end
        S_WB_LEN: state_q <= S_WB_FLG;
        S_WB_FLG: begin
          rint_q <= (mode_q != WB_MID);
          case (mode_q)
            WB_MID: begin
              hi_q    <= nhi_q;
              first_q <= 1'b0;
              state_q <= S_REFETCH;
            end
            WB_TRUNC: state_q <= S_DROP;
            default:  state_q <= S_IDLE;
          endcase
        end
        S_REFETCH: state_q <= S_GET_LO;
        S_DROP: if (take_w && rx_last_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // ownership is released only right after the length word went out
  p_len_before_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WB_FLG) |-> ($past(mem_we_o && state_q == S_WB_LEN) && !mem_wdata_o[15]));

  p_err_summary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WB_FLG) |-> (mem_wdata_o[8+FLG_ERR] == |mem_wdata_o[8+FLG_FRAM:8+FLG_BUFF]));

  p_single_int_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_int_o |=> !rx_int_o);

  p_miss_nowrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (!mem_we_o && !rx_int_o));

  p_byte_lane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA && mem_we_o) |-> $onehot(mem_be_o));

  p_ready_fetch_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> !rx_ready_o);
endmodule

// File: tb/rx_desc_writer_test.sv
`timescale 1ns/1ps
module rx_desc_writer_test;
  localparam int AW = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ring_base = AW'('h100);
  logic [15:0]   ring_cfg = {3'd2, 13'd0};
  logic          rx_valid = 1'b0, rx_last = 1'b0, rx_crc = 1'b0, rx_fram = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_ready, mem_req, mem_we, rx_int, miss;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;

  logic [15:0] mem [0:4095];
  int          wr_time [0:4095];
  int          wr_seq = 0;
  int          int_cnt = 0, miss_cnt = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  bit          first_ready;

  always #2 clk = ~clk;

  rx_desc_writer #(.MEM_AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(ring_base), .ring_cfg_i(ring_cfg),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .rx_crc_err_i(rx_crc), .rx_frame_err_i(rx_fram),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .rx_int_o(rx_int), .miss_o(miss)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      if (mem_be[1]) mem[mem_addr[11:0]][15:8] <= mem_wdata[15:8];
      if (mem_be[0]) mem[mem_addr[11:0]][7:0]  <= mem_wdata[7:0];
      wr_time[mem_addr[11:0]] <= wr_seq;
      wr_seq <= wr_seq + 1;
    end else if (mem_req) begin
      mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  always @(negedge clk) begin
    if (rx_int) int_cnt++;
    if (miss)   miss_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int dw(input int idx);
    return 'h100 + 4 * idx;
  endfunction

  function automatic logic [7:0] rd_byte(input int baddr);
    logic [15:0] w;
    w = mem[(baddr >> 1) & 'hfff];
    return baddr[0] ? w[7:0] : w[15:8];
  endfunction

  task automatic arm(input int idx, input int baddr, input int len, input bit own);
    mem[dw(idx)]     = 16'(baddr);
    mem[dw(idx) + 1] = {own ? 8'h80 : 8'h00, 8'(baddr >> 16)};
    mem[dw(idx) + 2] = 16'(-len) | 16'hf000;
    mem[dw(idx) + 3] = 16'h0;
  endtask

  task automatic send(input int n, input int seed, input bit crc, input bit fram);
    for (int k = 0; k < n; k++) begin
      rx_valid = 1'b1;
      rx_data  = 8'(seed + k);
      rx_last  = (k == n - 1);
      rx_crc   = (k == n - 1) && crc;
      rx_fram  = (k == n - 1) && fram;
      forever begin
        #1;
        if (k == 0 && !rx_ready) first_ready = 1'b0;
        if (rx_ready) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    rx_crc   = 1'b0;
    rx_fram  = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // count of mismatching bytes in a buffer region
  function automatic int bad_bytes(input int baddr, input int n, input int seed);
    int bad = 0;
    for (int k = 0; k < n; k++)
      if (rd_byte(baddr + k) != 8'(seed + k)) bad++;
    return bad;
  endfunction

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R11 ready in reset", int'(rx_ready), 0);
    chk("R11 req in reset", int'(mem_req), 0);
    chk("R11 int/miss in reset", int'(rx_int | miss), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", int'(rx_ready), 0);
  endtask

  task automatic t_single;
    for (int i = 0; i < 4; i++) arm(i, 'h100800 + i * 'h40 + (i == 1 ? 1 : 0), 16, 1'b1);
    first_ready = 1'b1;
    send(10, 'ha0, 1'b0, 1'b0);
    chk("R12 ready low during fetch", int'(first_ready), 0);
    chk("R2 single frame bytes", bad_bytes('h100800, 10, 'ha0), 0);
    chk("R3 single flag word", int'(mem[dw(0) + 1]), 'h0310);
    chk("R3 single msg length", int'(mem[dw(0) + 3]), 10);
    chk("R4 length before flag", int'(wr_time[dw(0) + 3] < wr_time[dw(0) + 1]), 1);
    chk("R9 one int for frame", int_cnt, 1);
  endtask

  task automatic t_chain;
    send(40, 'h10, 1'b1, 1'b0);
    chk("R5 first desc flag", int'(mem[dw(1) + 1]), 'h0210);
    chk("R5 first desc msg", int'(mem[dw(1) + 3]), 0);
    chk("R5 middle desc flag", int'(mem[dw(2) + 1]), 'h0010);
    chk("R6 last desc crc flag", int'(mem[dw(3) + 1]), 'h4910);
    chk("R3 chain msg total", int'(mem[dw(3) + 3]), 40);
    chk("R1 R2 bytes desc1 odd base", bad_bytes('h100841, 16, 'h10), 0);
    chk("R1 bytes desc2", bad_bytes('h100880, 16, 'h20), 0);
    chk("R1 bytes desc3", bad_bytes('h1008c0, 8, 'h30), 0);
    chk("R4 chain order", int'(wr_time[dw(3) + 3] < wr_time[dw(3) + 1]), 1);
    chk("R9 one int per chained frame", int_cnt, 2);
  endtask

  task automatic t_miss_wrap;
    int w0;
    w0 = wr_seq;
    send(6, 'h55, 1'b0, 1'b0);
    chk("R7 miss pulse", miss_cnt, 1);
    chk("R7 no writes on miss", wr_seq - w0, 0);
    chk("R7 no int on miss", int_cnt, 2);
    arm(0, 'h100800, 16, 1'b1);
    send(5, 'h70, 1'b0, 1'b1);
    chk("R10 R7 wrapped to desc0 flag", int'(mem[dw(0) + 1]), 'h6310);
    chk("R10 desc0 msg", int'(mem[dw(0) + 3]), 5);
    chk("R6 framing bytes", bad_bytes('h100800, 5, 'h70), 0);
  endtask

  task automatic t_trunc;
    arm(1, 'h100841, 8, 1'b1);
    send(20, 'hc0, 1'b0, 1'b0);
    chk("R8 trunc flag", int'(mem[dw(1) + 1]), 'h5610);
    chk("R8 trunc msg", int'(mem[dw(1) + 3]), 8);
    chk("R8 trunc bytes", bad_bytes('h100841, 8, 'hc0), 0);
    chk("R8 host desc untouched", int'(mem[dw(2) + 1]), 'h0010);
    chk("R9 R8 int on trunc", int_cnt, 4);
    send(3, 'h01, 1'b0, 1'b0);
    chk("R8 next frame misses", miss_cnt, 2);
  endtask

  task automatic finish_report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = '0;
      wr_time[i] = 0;
    end
    t_reset;
    t_single;
    t_chain;
    t_miss_wrap;
    t_trunc;
    done = 1'b1;
    finish_report;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_report;
    end
  end
endmodule